// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This engine works through a ring of transmit descriptors in a word-wide memory. Each descriptor is four 32-bit words. The engine reads all four words and checks whether it owns the descriptor. If it does, it reads the descriptor's data buffers, up to two of them, and sends their bytes one per cycle on a byte stream. The stream marks the start and the end of each frame. Afterwards it writes the first descriptor word back with the ownership flag cleared. When the descriptor asks for it, the engine then raises a one-cycle interrupt. One frame may be split over several descriptors. The first-segment flag and the last-segment flag mark where the frame begins and ends.

Software fills the descriptors, sets their ownership flags and pulses the poll input. The engine keeps processing descriptors, in ring order, until it fetches one that the host still owns. It then stops and waits for the next poll, and fetches that same descriptor again. The host learns that a descriptor and its buffers are free again by seeing the ownership flag read back as zero.

The memory port has a fixed read latency of one cycle. A read issued in one cycle returns its data on `mem_rdata` in the next cycle. A write takes effect at the clock edge that ends its cycle.

Top module: `txdesc_walker`

## Requirements
- R1: Following reset, `tx_valid`, `mem_req` and `tx_irq` are all 0. They stay 0 until a poll pulse arrives.
- R2: One cycle after a poll pulse is sampled, the engine reads the descriptor at `RING_BASE + 16*index`. It reads the four words at increasing word addresses, one word per cycle. Word 0 holds the flags: bit 31 is the ownership flag (1 means the engine owns the descriptor), bit 30 requests an interrupt, bit 29 marks the last segment and bit 28 marks the first segment. Word 1 holds the two byte counts: buffer A in bits [12:0] and buffer B in bits [28:16]. Word 2 holds the byte address of buffer A and word 3 holds the byte address of buffer B.
- R3: A descriptor fetched with bit 31 at 0 produces no bytes and no write. The engine makes no further memory access until the next poll. After that poll it fetches the same descriptor again.
- R4: The bytes of buffer A are sent first and the bytes of buffer B after them. Within a buffer the bytes go out in increasing address order, one byte per `tx_valid` cycle. The byte at address a is taken from bits [8*(a mod 4)+7 : 8*(a mod 4)] of the word at address a with its two low bits cleared. A buffer may start at any alignment.
- R5: A buffer whose byte count is zero is skipped and never read.
- R6: `tx_sof` is 1 on the first byte of a descriptor that has bit 28 set. `tx_eof` is 1 on the final byte of a descriptor that has bit 29 set. Both markers are only ever 1 together with `tx_valid`.
- R7: After the last byte of an owned descriptor, the engine makes exactly one write, to that descriptor's word 0. The written value is the word 0 that was fetched, with bit 31 cleared and every other bit unchanged.
- R8: `tx_irq` is high for exactly one cycle, the cycle after the write-back of a descriptor that has both bit 30 and bit 29 set. At all other times it is 0.
- R9: After each write-back, the index advances by one and the next descriptor address is 16 bytes higher. After descriptor `RING_LEN-1` the next fetch goes back to `RING_BASE`.
- R10: A poll pulse that arrives while the engine is fetching, streaming or writing back has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll | input | 1 | Starts or resumes the ring walk while the engine is idle |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after the read |
| tx_valid | output | 1 | A byte is on `tx_data` |
| tx_data | output | 8 | Stream byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| tx_irq | output | 1 | Completion interrupt pulse |

## Verification
The first fetch address is due exactly one cycle after the poll pulse. The bench samples it at that falling edge after every poll.

Two results have fixed delays:
- Each buffer word is read two cycles before the first byte taken from it.
- The interrupt follows its write-back by exactly one cycle.

The bench does not tie bytes and writes to absolute cycle numbers. Instead, a reference model keeps queues of the expected bytes (with their markers) and of the expected write-backs. At every falling edge it pops and compares any byte or write that appears, and it compares `tx_irq` against whether the write in the previous cycle asked for an interrupt. During suspension the bench watches the memory port for quiet.

// File: rtl/txdw_pkg.sv
package txdw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_CHECK,
        S_RD,
        S_CAP,
        S_EMIT,
        S_WB
    } state_t;

    localparam int CNT_W = 13;

    typedef struct packed {
        logic             own;
        logic             irq_req;
        logic             last;
        logic             first;
        logic [CNT_W-1:0] cnt_a;
        logic [CNT_W-1:0] cnt_b;
    } dflags_t;

endpackage

// File: rtl/txdw_desc_fields.sv
module txdw_desc_fields
    import txdw_pkg::*;
(
    input  logic [31:0] word0,
    input  logic [31:0] word1,
    output dflags_t     flags
);
    logic unused_bits;
    assign unused_bits = ^{word0[27:0], word1[31:29], word1[15:13]};

    always_comb begin
        flags.own     = word0[31];
        flags.irq_req = word0[30];
        flags.last    = word0[29];
        flags.first   = word0[28];
        flags.cnt_a   = word1[CNT_W-1:0];
        flags.cnt_b   = word1[16 +: CNT_W];
    end
endmodule

// File: rtl/txdw_lane_pick.sv
module txdw_lane_pick #(
    parameter int LANES = 4
) (
    input  logic [LANES*8-1:0]         word,
    input  logic [$clog2(LANES)-1:0]   lane,
    output logic [7:0]                 byte_out
);
    logic [7:0] lanes_w [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes_w[g] = word[g*8 +: 8];
    end

    assign byte_out = lanes_w[lane];
endmodule

// File: rtl/txdw_ring_ptr.sv
module txdw_ring_ptr #(
    parameter logic [31:0] RING_BASE = 32'h0000_0100,
    parameter int          RING_LEN  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        advance,
    output logic [31:0] desc_addr
);
    localparam int IDX_W = (RING_LEN > 1) ? $clog2(RING_LEN) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_LEN - 1);

    logic [IDX_W-1:0] index_d, index_q;

    always_comb begin
        index_d = index_q;
        if (advance) begin
            index_d = (index_q == LAST_IDX) ? '0 : index_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) index_q <= '0;
        else        index_q <= index_d;
    end

    assign desc_addr = RING_BASE + (32'(index_q) << 4);

    p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && index_q == LAST_IDX) |=> (desc_addr == RING_BASE));

    p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && index_q != LAST_IDX) |=> (desc_addr == $past(desc_addr) + 32'd16));
endmodule

// File: rtl/txdesc_walker.sv
module txdesc_walker
    import txdw_pkg::*;
#(
    parameter logic [31:0] RING_BASE = 32'h0000_0100,
    parameter int          RING_LEN  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        poll,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_sof,
    output logic        tx_eof,
    output logic        tx_irq
);
    typedef struct packed {
        state_t           state;
        logic [2:0]       fidx;
        logic [31:0]      w0;
        logic [31:0]      w1;
        logic [31:0]      w2;
        logic [31:0]      w3;
        logic             use_b;
        logic [31:0]      addr;
        logic [CNT_W-1:0] remain;
        logic [31:0]      word;
        logic             sof_pend;
        logic             irq;
    } regs_t;

    localparam regs_t REGS_RST = '{state: S_IDLE, default: '0};

    regs_t       r_d, r_q;
    dflags_t     f;
    logic        advance;
    logic [31:0] desc_addr;
    logic [7:0]  lane_byte;
    logic        last_beat;

    txdw_desc_fields u_fields (
        .word0 (r_q.w0),
        .word1 (r_q.w1),
        .flags (f)
    );

    txdw_ring_ptr #(
        .RING_BASE (RING_BASE),
        .RING_LEN  (RING_LEN)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .desc_addr (desc_addr)
    );

    txdw_lane_pick #(.LANES(4)) u_lane (
        .word     (r_q.word),
        .lane     (r_q.addr[1:0]),
        .byte_out (lane_byte)
    );

    assign last_beat = (r_q.remain == CNT_W'(1));

    always_comb begin
        r_d     = r_q;
        r_d.irq = 1'b0;
        advance = 1'b0;
        case (r_q.state)
            S_IDLE: begin
                if (poll) begin
                    r_d.state = S_FETCH;
                    r_d.fidx  = '0;
                end
            end
            S_FETCH: begin
                case (r_q.fidx)
                    3'd1:    r_d.w0 = mem_rdata;
                    3'd2:    r_d.w1 = mem_rdata;
                    3'd3:    r_d.w2 = mem_rdata;
                    3'd4:    r_d.w3 = mem_rdata;
                    default: ;
                endcase
                r_d.fidx = r_q.fidx + 3'd1;
                if (r_q.fidx == 3'd4) r_d.state = S_CHECK;
            end
            S_CHECK: begin
                r_d.sof_pend = f.first;
                if (!f.own) begin
                    r_d.state = S_IDLE;
                end else if (f.cnt_a != '0) begin
                    r_d.use_b  = 1'b0;
                    r_d.addr   = r_q.w2;
                    r_d.remain = f.cnt_a;
                    r_d.state  = S_RD;
                end else if (f.cnt_b != '0) begin
                    r_d.use_b  = 1'b1;
                    r_d.addr   = r_q.w3;
                    r_d.remain = f.cnt_b;
                    r_d.state  = S_RD;
                end else begin
                    r_d.state = S_WB;
                end
            end
            S_RD:  r_d.state = S_CAP;
            S_CAP: begin
                r_d.word  = mem_rdata;
                r_d.state = S_EMIT;
            end
            S_EMIT: begin
                r_d.sof_pend = 1'b0;
                if (last_beat) begin
                    if (!r_q.use_b && f.cnt_b != '0) begin
                        r_d.use_b  = 1'b1;
                        r_d.addr   = r_q.w3;
                        r_d.remain = f.cnt_b;
                        r_d.state  = S_RD;
                    end else begin
                        r_d.state = S_WB;
                    end
                end else begin
                    r_d.addr   = r_q.addr + 32'd1;
                    r_d.remain = r_q.remain - CNT_W'(1);
                    r_d.state  = (r_q.addr[1:0] == 2'b11) ? S_RD : S_EMIT;
                end
            end
            S_WB: begin
                advance   = 1'b1;
                r_d.irq   = f.irq_req && f.last;
                r_d.state = S_FETCH;
                r_d.fidx  = '0;
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_addr;
        mem_wdata = {1'b0, r_q.w0[30:0]};
        case (r_q.state)
            S_FETCH: begin
                mem_req  = (r_q.fidx < 3'd4);
                mem_addr = desc_addr + {27'd0, r_q.fidx, 2'b00};
            end
            S_RD: begin
                mem_req  = 1'b1;
                mem_addr = {r_q.addr[31:2], 2'b00};
            end
            S_WB: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end

    assign tx_valid = (r_q.state == S_EMIT);
    assign tx_data  = lane_byte;
    assign tx_sof   = tx_valid && r_q.sof_pend;
    assign tx_eof   = tx_valid && f.last && last_beat && (r_q.use_b || f.cnt_b == '0);
    assign tx_irq   = r_q.irq;

    p_wb_clears_own_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !mem_wdata[31]);

    p_irq_after_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> $past(mem_we));

    p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    p_marks_in_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sof || tx_eof) |-> tx_valid);

    p_no_emit_unowned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid || mem_we) |-> r_q.w0[31]);
endmodule

// File: tb/txdesc_walker_test.sv
module txdesc_walker_test;
    localparam logic [31:0] BASE = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n, poll;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_valid, tx_sof, tx_eof, tx_irq;
    logic [7:0]  tx_data;

    always #4 clk = ~clk;

    txdesc_walker #(.RING_BASE(BASE), .RING_LEN(4)) uut (
        .clk(clk), .rst_n(rst_n), .poll(poll),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_sof(tx_sof),
        .tx_eof(tx_eof), .tx_irq(tx_irq)
    );

    logic [31:0] mem [0:1023];
    logic [31:0] rdata_q;
    assign mem_rdata = rdata_q;

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
            else        rdata_q <= mem[mem_addr[11:2]];
        end
    end

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [9:0]  exp_bytes [$];
    logic [63:0] exp_wr [$];
    bit          irq_due = 0;

    function automatic logic [7:0] pat(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic put_desc(input int i, input bit own, input bit ic, input bit ls,
                            input bit fs, input int ca, input int aa,
                            input int cb, input int ab, input bit expect_it);
        logic [31:0] w0;
        int base_w, n, total;
        w0 = {own, ic, ls, fs, 12'h0, 16'(16'hA500 + i)};
        base_w = int'(BASE >> 2) + 4 * i;
        mem[base_w]     = w0;
        mem[base_w + 1] = {3'b0, 13'(cb), 3'b0, 13'(ca)};
        mem[base_w + 2] = aa;
        mem[base_w + 3] = ab;
        if (expect_it) begin
            total = ca + cb;
            n = 0;
            for (int k = 0; k < ca; k++) begin
                exp_bytes.push_back({fs && n == 0, ls && n == total - 1, pat(aa + k)});
                n++;
            end
            for (int k = 0; k < cb; k++) begin
                exp_bytes.push_back({fs && n == 0, ls && n == total - 1, pat(ab + k)});
                n++;
            end
            exp_wr.push_back({BASE + 32'(16 * i), w0 & 32'h7FFF_FFFF});
        end
    endtask

    task automatic kick(input logic [31:0] a, input string tag);
        @(negedge clk) poll = 1'b1;
        @(negedge clk) poll = 1'b0;
        check(mem_req && !mem_we && mem_addr == a, tag, "first fetch address", mem_addr, a);
        @(negedge clk);
        check(mem_req && mem_addr == a + 32'd4, "R2", "second fetch address",
              mem_addr, a + 32'd4);
    endtask

    task automatic drain();
        wait (exp_bytes.size() == 0 && exp_wr.size() == 0);
        repeat (40) @(negedge clk);
    endtask

    // Reference model: compares stream, write-backs and interrupt every cycle
    always @(negedge clk) begin
        if (rst_n) begin
            logic [9:0]  eb;
            logic [63:0] ew;
            check(tx_irq == irq_due, "R8", "tx_irq", tx_irq, irq_due);
            irq_due = 0;
            if (tx_valid) begin
                if (exp_bytes.size() == 0) begin
                    check(0, "R4", "unexpected byte", tx_data, 0);
                end else begin
                    eb = exp_bytes.pop_front();
                    check(tx_data == eb[7:0], "R4", "byte", tx_data, eb[7:0]);
                    check({tx_sof, tx_eof} == eb[9:8], "R6", "sof/eof", {tx_sof, tx_eof}, eb[9:8]);
                end
            end
            if (mem_req && mem_we) begin
                if (exp_wr.size() == 0) begin
                    check(0, "R7", "unexpected write", mem_addr, 0);
                end else begin
                    ew = exp_wr.pop_front();
                    check({mem_addr, mem_wdata} == ew, "R7", "write-back", {mem_addr, mem_wdata}, ew);
                    irq_due = ew[30] && ew[29];
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            check(0, "watchdog", "run did not complete", cycles, 50000);
            summary();
        end
    end

    initial begin
        int busy;
        for (int w = 0; w < 1024; w++)
            mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
        rdata_q = '0;
        rst_n = 1'b0;
        poll  = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet after reset until poll
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            check(!tx_valid && !mem_req && !tx_irq, "R1", "idle outputs",
                  {tx_valid, mem_req, tx_irq}, 0);
        end

        // Frame across desc0/desc1 (R5 skips), desc2 both buffers, desc3 host-owned
        put_desc(0, 1, 0, 0, 1, 5, 32'h401, 0, 32'h0, 1);
        put_desc(1, 1, 1, 1, 0, 0, 32'h0, 6, 32'h502, 1);
        put_desc(2, 1, 1, 1, 1, 3, 32'h600, 2, 32'h613, 1);
        put_desc(3, 0, 0, 1, 1, 4, 32'h700, 0, 32'h0, 0);
        kick(BASE, "R2");
        repeat (25) @(negedge clk);
        poll = 1'b1;                 // R10: poll while busy
        @(negedge clk) poll = 1'b0;
        drain();

        // R3: suspended, no memory access
        busy = 0;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (mem_req) busy++;
        end
        check(busy == 0, "R3", "accesses while suspended", busy, 0);

        // R3: same descriptor fetched again after poll
        put_desc(3, 1, 0, 1, 1, 4, 32'h700, 0, 32'h0, 1);
        kick(BASE + 32'd48, "R3");
        drain();

        // R9: wrapped to desc0, found host-owned; refill and resume
        check(mem[(BASE >> 2) + 12][31] == 1'b0, "R7", "desc3 own cleared",
              mem[(BASE >> 2) + 12], 0);
        put_desc(0, 1, 1, 1, 1, 2, 32'h800, 1, 32'h81F, 1);
        kick(BASE, "R9");
        drain();

        check(exp_bytes.size() == 0, "R4", "bytes outstanding", exp_bytes.size(), 0);
        check(mem[(BASE >> 2)][31] == 1'b0, "R7", "desc0 own cleared", mem[(BASE >> 2)], 0);
        summary();
    end
endmodule